// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer

This block turns a comparison bit and three control levels into the four gate-enable signals of an H-bridge. Each leg has an upper and a lower switch. The comparison bit picks the diagonal that conducts. One bit of the comparison steers current one way through the load and the other bit steers it back. A high-side enable level can hold both upper switches off. The load current then freewheels through a lower switch. A disable level or an undervoltage flag shuts every gate off at once, without waiting on any clock.

Turning a switch off takes a single register stage after the synchronised target changes. Turning a switch on waits a programmable number of cycles, and the upper and lower switches have separate counts. This keeps the two switches of a leg from ever conducting together. A turn-on request that drops before its count finishes starts the count again from zero.

When the bridge comes out of disable or undervoltage, both lower switches are first driven on together for a refresh interval so that the bootstrap supplies charge. The upper switches stay blocked until a longer enable interval has passed since the release. All four control inputs pass through a two-flop synchroniser.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `dis_i` or `uv_i` is high, all four gate outputs are low in the same cycle, whatever the other inputs and the state are.
- R2: With compare 1, high-side enable 1 and no recovery window active, the settled output is A-upper and B-lower on, and the other two gates off.
- R3: With compare 0, high-side enable 1 and no recovery window active, the settled output is A-lower and B-upper on, and the other two gates off.
- R4: With high-side enable 0, both upper gates are off. Compare 1 leaves only B-lower on and compare 0 leaves only A-lower on.
- R5: A gate whose target drops to 0 goes low at the third rising edge after the input change: two synchroniser edges and one output register edge.
- R6: An upper gate goes high at edge 3+HI_DLY after its target rises, counted from the input change. A lower gate does so at edge 3+LO_DLY. The two counts are independent parameters.
- R7: If a gate's target falls back to 0 before its turn-on count completes, the count restarts. An input pulse lasting LO_DLY cycles never turns a lower gate on.
- R8: After disable or undervoltage falls, both lower gates are targeted on for REFRESH_CYC cycles. The refresh window starts at the second edge after release, and no upper gate is on during it.
- R9: The upper gates are blocked until UEN_CYC cycles after the synchronised release, with UEN_CYC greater than REFRESH_CYC. An upper gate therefore rises at edge UEN_CYC+3+HI_DLY after release.
- R10: The upper and lower gates of one leg are never high in the same cycle.
- R11: While `rst_n` is low, at a rising edge, all outputs are low and the recovery counter is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 1 | Comparison bit selecting the conducting diagonal |
| hs_en_i | input | 1 | High-side enable; 0 holds both upper gates off |
| dis_i | input | 1 | Disable; 1 forces all gates off |
| uv_i | input | 1 | Undervoltage flag; 1 forces all gates off |
| a_hi_o | output | 1 | Leg A upper gate enable |
| a_lo_o | output | 1 | Leg A lower gate enable |
| b_hi_o | output | 1 | Leg B upper gate enable |
| b_lo_o | output | 1 | Leg B lower gate enable |

## Verification
Suppose a turn-on counter fails to clear. A gate would then rise fewer cycles after its target than the delay parameter allows, or a short input pulse would reach the output. Either shows up within a few cycles of the stimulus as an output that changes on the wrong edge.

Suppose the recovery counter is wrong. The lower refresh pulse would then end on the wrong edge, or an upper gate would appear before the enable interval has passed. Both are visible at the ports within about UEN_CYC cycles of a release.

A broken leg interlock would show up as both gates of one leg high in the same sampled cycle.

// File: rtl/hb_pkg.sv
// Package: shared gate indices and vector type for the full-bridge sequencer.
// Assumes four gates; the bit order below is used by every module and the bench.
package hb_pkg;
    localparam int NUM_GATES = 4;
    localparam int G_A_HI = 3;
    localparam int G_A_LO = 2;
    localparam int G_B_HI = 1;
    localparam int G_B_LO = 0;

    typedef logic [NUM_GATES-1:0] gate_vec_t;

    // True for the index of an upper (high-side) gate.
    function automatic bit is_upper(input int idx);
        return (idx == G_A_HI) || (idx == G_B_HI);
    endfunction
endpackage

// File: rtl/hb_sync.sv
// Module: two-flop synchroniser for a vector of level inputs.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module hb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/hb_recovery.sv
// Module: recovery timer after a fault (disable or undervoltage) is released.
// Produces a lower-switch refresh window and a later upper-switch permit.
// Assumes UEN_CYC > REFRESH_CYC >= 1; the fault input is already synchronised.
module hb_recovery #(
    parameter int REFRESH_CYC = 76,
    parameter int UEN_CYC     = 126
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_s_i,
    output logic refresh_o,
    output logic upper_ok_o
);
    localparam int CW = $clog2(UEN_CYC + 1);
    localparam logic [CW-1:0] REF_L = CW'(REFRESH_CYC);
    localparam logic [CW-1:0] UEN_L = CW'(UEN_CYC);

    logic [CW-1:0] rec_cnt;

    // Count cycles since release; clear during fault, saturate at the permit value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt <= '0;
        end else if (fault_s_i) begin
            rec_cnt <= '0;
        end else if (rec_cnt != UEN_L) begin
            rec_cnt <= rec_cnt + 1'b1;
        end
    end

    // Window decode from the counter.
    always_comb begin
        refresh_o  = !fault_s_i && (rec_cnt < REF_L);
        upper_ok_o = !fault_s_i && (rec_cnt == UEN_L);
    end

    // Permit and refresh are never active together.
    assert_permit_after_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upper_ok_o |-> !refresh_o);
    // The permit can only appear after a cycle free of fault.
    assert_permit_needs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upper_ok_o) |-> $past(!fault_s_i));
endmodule

// File: rtl/hb_decode.sv
// Module: combinational target decode for the four bridge gates.
// Priority: fault, then refresh window, then comparison with high-side masking.
// Assumes all inputs are synchronised; the outputs are targets, not gate drives.
module hb_decode
    import hb_pkg::*;
(
    input  logic      cmp_s_i,
    input  logic      hs_s_i,
    input  logic      fault_s_i,
    input  logic      refresh_i,
    input  logic      upper_ok_i,
    output gate_vec_t tgt_o
);
    logic hi_allowed;

    // Upper switches need both the enable input and the recovery permit.
    always_comb hi_allowed = hs_s_i && upper_ok_i;

    // Select the target state by priority.
    always_comb begin
        tgt_o = '0;
        if (fault_s_i) begin
            tgt_o = '0;
        end else if (refresh_i) begin
            tgt_o[G_A_LO] = 1'b1;
            tgt_o[G_B_LO] = 1'b1;
        end else if (cmp_s_i) begin
            tgt_o[G_A_HI] = hi_allowed;
            tgt_o[G_B_LO] = 1'b1;
        end else begin
            tgt_o[G_B_HI] = hi_allowed;
            tgt_o[G_A_LO] = 1'b1;
        end
    end
endmodule

// File: rtl/hb_ondelay.sv
// Module: per-gate asymmetric delay. Turn-off is taken at the next edge;
// turn-on waits until the target has been held for DLY further cycles.
// Assumes DLY >= 0; a target drop restarts the count.
module hb_ondelay #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_i,
    output logic gate_o
);
    localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    logic [CW-1:0] cnt;

    // Count target-high cycles and raise the gate at the limit; clear on target drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            gate_o <= 1'b0;
        end else if (!tgt_i) begin
            cnt    <= '0;
            gate_o <= 1'b0;
        end else if (!gate_o) begin
            if (cnt == LIMIT) begin
                gate_o <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Turn-off follows a dropped target at the next edge.
    assert_off_next_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_i |=> !gate_o);
    // A rising gate had its target in the previous cycle.
    assert_rise_has_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(tgt_i));

    generate
        if (DLY >= 1) begin : g_hold_chk
            // With a nonzero delay the target was also held two cycles back.
            assert_rise_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gate_o) |-> $past(tgt_i, 2));
        end
    endgenerate
endmodule

// File: rtl/hbridge_gate_seq.sv
// Module: top of the full-bridge gate sequencer. Synchronises the controls,
// runs the recovery timer, decodes targets and applies per-gate turn-on delays.
// Disable and undervoltage also gate the outputs combinationally.
// Assumes UEN_CYC > REFRESH_CYC > LO_DLY so the refresh pulse reaches the gates.
module hbridge_gate_seq #(
    parameter int HI_DLY      = 3,
    parameter int LO_DLY      = 2,
    parameter int REFRESH_CYC = 76,
    parameter int UEN_CYC     = 126
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    input  logic hs_en_i,
    input  logic dis_i,
    input  logic uv_i,
    output logic a_hi_o,
    output logic a_lo_o,
    output logic b_hi_o,
    output logic b_lo_o
);
    import hb_pkg::*;

    localparam int NSYNC = 4;
    localparam int S_CMP = 0;
    localparam int S_HS  = 1;
    localparam int S_DIS = 2;
    localparam int S_UV  = 3;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn_in;
    logic             fault_s;
    logic             fault_raw;
    logic             refresh;
    logic             upper_ok;
    gate_vec_t        tgt;
    gate_vec_t        gate_q;
    gate_vec_t        gate_out;

    // Gather raw controls for the synchroniser.
    always_comb raw_in = {uv_i, dis_i, hs_en_i, cmp_i};

    hb_sync #(.W(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    // Synchronised and raw fault levels.
    always_comb begin
        fault_s   = syn_in[S_DIS] | syn_in[S_UV];
        fault_raw = dis_i | uv_i;
    end

    hb_recovery #(.REFRESH_CYC(REFRESH_CYC), .UEN_CYC(UEN_CYC)) u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_s_i  (fault_s),
        .refresh_o  (refresh),
        .upper_ok_o (upper_ok)
    );

    hb_decode u_dec (
        .cmp_s_i    (syn_in[S_CMP]),
        .hs_s_i     (syn_in[S_HS]),
        .fault_s_i  (fault_s),
        .refresh_i  (refresh),
        .upper_ok_i (upper_ok),
        .tgt_o      (tgt)
    );

    generate
        for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
            localparam int GD = is_upper(g) ? HI_DLY : LO_DLY;
            hb_ondelay #(.DLY(GD)) u_dly (
                .clk    (clk),
                .rst_n  (rst_n),
                .tgt_i  (tgt[g]),
                .gate_o (gate_q[g])
            );
        end
    endgenerate

    // Asynchronous shutdown mask on the registered gates.
    always_comb begin
        gate_out = gate_q & {NUM_GATES{~fault_raw}};
        a_hi_o   = gate_out[G_A_HI];
        a_lo_o   = gate_out[G_A_LO];
        b_hi_o   = gate_out[G_B_HI];
        b_lo_o   = gate_out[G_B_LO];
    end

    // Fault inputs hold every output low.
    assert_fault_all_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_i || uv_i) |-> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));
    // Leg A never conducts through both switches.
    assert_leg_a_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi_o && a_lo_o));
    // Leg B never conducts through both switches.
    assert_leg_b_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_hi_o && b_lo_o));
    // No upper gate is on inside the refresh window.
    assert_refresh_no_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> !(gate_q[G_A_HI] || gate_q[G_B_HI]));
    // Synchronised high-side enable low clears the upper gates by the next edge.
    assert_hs_low_upper_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_in[S_HS] |=> !(gate_q[G_A_HI] || gate_q[G_B_HI]));
endmodule

// File: tb/hbridge_gate_seq_test.sv
`timescale 1ns/1ps
module hbridge_gate_seq_test;
    localparam int HI  = 3;
    localparam int LO  = 2;
    localparam int REF = 76;
    localparam int UEN = 126;
    localparam int WATCHDOG_CYC = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_i = 1'b1, hs_en_i = 1'b1, dis_i = 1'b1, uv_i = 1'b0;
    logic a_hi_o, a_lo_o, b_hi_o, b_lo_o;

    always #2.5 clk = ~clk;

    hbridge_gate_seq #(.HI_DLY(HI), .LO_DLY(LO), .REFRESH_CYC(REF), .UEN_CYC(UEN)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .hs_en_i(hs_en_i),
        .dis_i(dis_i), .uv_i(uv_i),
        .a_hi_o(a_hi_o), .a_lo_o(a_lo_o), .b_hi_o(b_hi_o), .b_lo_o(b_lo_o)
    );

    // Packed view {a_hi, a_lo, b_hi, b_lo}
    wire [3:0] gates = {a_hi_o, a_lo_o, b_hi_o, b_lo_o};

    int cyc = 0, checks = 0, errors = 0, base = 0;
    bit finished = 1'b0;
    int        q_due[$];
    logic [3:0] q_exp[$];
    string     q_req[$];

    // Monitor: count negedges, check leg exclusivity, pop due expectations.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            checks++;
            if ((a_hi_o && a_lo_o) || (b_hi_o && b_lo_o)) begin
                errors++;
                $display("FAIL R10 cycle %0d: gates %b, expected no leg overlap", cyc, gates);
            end
        end
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            int        d;
            logic [3:0] e;
            string     r;
            d = q_due.pop_front();
            e = q_exp.pop_front();
            r = q_req.pop_front();
            checks++;
            if (gates !== e) begin
                errors++;
                $display("FAIL %s cycle %0d: gates %b, expected %b", r, cyc, gates, e);
            end
        end
    end

    // Driver: change inputs just after a rising edge and mark the reference.
    task automatic apply(input logic c, input logic h, input logic d, input logic u);
        @(posedge clk); #1;
        cmp_i = c; hs_en_i = h; dis_i = d; uv_i = u;
        base = cyc;
    endtask

    // Expect value at the k-th negedge after the reference edge (k=0 same cycle).
    task automatic expect_at(input int k, input logic [3:0] e, input string r);
        q_due.push_back(base + 1 + k);
        q_exp.push_back(e);
        q_req.push_back(r);
    endtask

    task automatic drain();
        while (q_due.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        // R11: reset state
        @(posedge clk); #1; base = cyc;
        expect_at(0, 4'b0000, "R11");
        expect_at(2, 4'b0000, "R11");
        drain();
        @(posedge clk); #1; rst_n = 1'b1;

        // R1: held disable keeps outputs low
        apply(1'b1, 1'b1, 1'b1, 1'b0);
        expect_at(6, 4'b0000, "R1");
        drain();

        // R8/R9/R2: release disable with compare 1
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        expect_at(4, 4'b0000, "R8");
        expect_at(5, 4'b0101, "R8");
        expect_at(REF + 2, 4'b0101, "R8");
        expect_at(REF + 3, 4'b0001, "R8");
        expect_at(UEN + 2 + HI, 4'b0001, "R9");
        expect_at(UEN + 3 + HI, 4'b1001, "R9");
        drain();

        // R3/R5/R6: swap diagonal
        apply(1'b0, 1'b1, 1'b0, 1'b0);
        expect_at(2, 4'b1001, "R5");
        expect_at(3, 4'b0000, "R5");
        expect_at(LO + 2, 4'b0000, "R6");
        expect_at(LO + 3, 4'b0100, "R6");
        expect_at(HI + 2, 4'b0100, "R6");
        expect_at(HI + 3, 4'b0110, "R3");
        drain();

        // R4: drop high-side enable with compare 0
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        expect_at(2, 4'b0110, "R4");
        expect_at(3, 4'b0100, "R4");
        drain();

        // R4: compare 1 while high side disabled
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        expect_at(3, 4'b0000, "R5");
        expect_at(LO + 3, 4'b0001, "R4");
        drain();

        // R2/R6: re-enable high side
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        expect_at(HI + 2, 4'b0001, "R6");
        expect_at(HI + 3, 4'b1001, "R2");
        drain();

        // R7: compare 0 pulse lasting LO cycles never turns A-lower on
        apply(1'b0, 1'b1, 1'b0, 1'b0);
        expect_at(2, 4'b1001, "R7");
        for (int k = 3; k <= 2 + 2 * LO; k++) expect_at(k, 4'b0000, "R7");
        for (int k = 3 + 2 * LO; k <= 2 + LO + HI; k++) expect_at(k, 4'b0001, "R7");
        expect_at(3 + LO + HI, 4'b1001, "R7");
        repeat (LO) @(posedge clk);
        #1; cmp_i = 1'b1;
        drain();

        // R1: undervoltage forces low in the same cycle
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        expect_at(0, 4'b0000, "R1");
        expect_at(6, 4'b0000, "R1");
        drain();

        // R8/R9: recovery from undervoltage
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        expect_at(4, 4'b0000, "R8");
        expect_at(5, 4'b0101, "R8");
        expect_at(UEN + 2 + HI, 4'b0001, "R9");
        expect_at(UEN + 3 + HI, 4'b1001, "R9");
        drain();

        // R1: disable while running
        apply(1'b1, 1'b1, 1'b1, 1'b0);
        expect_at(0, 4'b0000, "R1");
        drain();

        // R10: randomized stimulus, leg overlap watched by the monitor
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            cmp_i   = 1'($urandom % 2);
            hs_en_i = 1'($urandom % 4 != 0);
            dis_i   = 1'($urandom % 64 == 0);
            uv_i    = 1'($urandom % 97 == 0);
        end
        apply(1'b1, 1'b1, 1'b1, 1'b0);
        expect_at(0, 4'b0000, "R1");
        drain();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected finish within %0d cycles", WATCHDOG_CYC);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule